// File: doc/BRIEF.md
# Tunable Nanosecond Time-of-Day Counter

This block keeps a time-of-day value for precision time synchronisation: a seconds count and a nanoseconds count. The nanoseconds count carries an integer part and a sub-nanosecond fraction. Every rising edge of its clock adds an active step, the period, to the nanoseconds count. When the sum reaches the programmable modulus, the modulus is subtracted and the seconds count advances by one. Because the period has a fractional part, a clock whose frequency is not an exact number of nanoseconds can still track real time.

Software drives the block through a 32-bit register port addressed in words. It can stage a new time, a new period and a temporary adjustment, then commit each one with a command bit in the control register. A command fires only when its bit goes from 0 to 1 relative to the last value written to the control register, so software writes 0 there before each command. The adjustment replaces the period for a programmed number of ticks and then hands back to the normal period. This lets a servo slew the time without stepping it. To read the time, software issues a snapshot command, polls the snapshot flag, and then reads four words that were all captured on the same edge. The port carries register accesses only and has no data stream, so no valid/ready handshake applies. A write takes effect on the clock edge where `wr_en` is high, and reads are combinational on `addr`.

Top module: `tod_clock`

## Requirements
- R1: After reset, the staged and active period is 8.0 ns, the modulus is MOD_INIT.0, the time and snapshot registers are zero, and the control word reads 0.
- R2: On each edge with no load or clear, the active step is added to the nanoseconds count. This includes the 8-bit fraction, which carries into the integer part.
- R3: When the sum reaches or passes the modulus, the nanoseconds count becomes the sum minus the modulus and seconds increments, carrying from the low 32 bits into the high 16 bits of the 48-bit seconds.
- R4: A command acts only on the edge of a control write in which its bit is 1 and the previously written control value had it 0. Command bits are bit0 snapshot, bit1 start adjustment, bit2 apply period, bit3 apply time, bit4 clear.
- R5: The apply-time command makes the staged seconds and nanoseconds the time on that edge, and the tick of that edge is discarded. Counting resumes from the loaded value on the next edge.
- R6: Writes to the period words (word 8 integer, word 9 fraction) change only the staged copy. The counting rate changes only on an apply-period command.
- R7: The start-adjustment command latches the tick count (word 12) and the alternate period (word 14 integer, word 15 fraction). The next N edges step by the alternate period, and later edges step by the normal period again. A count of 0 means no adjustment.
- R8: The snapshot command copies the time present before its edge into the read words (16 seconds high, 17 seconds low, 18 ns integer, 19 ns fraction) and sets control read bit0. That bit stays 1 until a control write with bit0 = 0.
- R9: The clear command zeroes seconds, nanoseconds and any adjustment in progress, and leaves the period and modulus registers unchanged. If clear and apply-time fire on the same edge, clear wins.
- R10: Word map: 0 control, 4..7 staged seconds high/low and ns integer/fraction, 8..9 period, 10..11 modulus, 12 adjust count, 14..15 adjust period, 16..19 snapshot. Bits beyond each field's width, and unmapped words, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock; one tick per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 6 | Word index for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the word at `addr`, combinational |

## Verification
The bench builds the block with MOD_INIT set to 1000 and all widths at their defaults: 48-bit seconds, 30-bit integer nanoseconds and 8-bit fraction. The small modulus brings seconds rollover within a few ticks straight out of reset. The full 48-bit seconds carry is still reached by loading 0xFFFFFFFF into the low seconds word. One vector also reprograms the modulus to 500, which shows the wrap point follows the register and not the reset value.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // word indices of the register port
  localparam logic [5:0] W_CTRL   = 6'd0;
  localparam logic [5:0] W_LSEC_H = 6'd4;
  localparam logic [5:0] W_LSEC_L = 6'd5;
  localparam logic [5:0] W_LNS_I  = 6'd6;
  localparam logic [5:0] W_LNS_F  = 6'd7;
  localparam logic [5:0] W_PER_I  = 6'd8;
  localparam logic [5:0] W_PER_F  = 6'd9;
  localparam logic [5:0] W_MOD_I  = 6'd10;
  localparam logic [5:0] W_MOD_F  = 6'd11;
  localparam logic [5:0] W_ADJ_N  = 6'd12;
  localparam logic [5:0] W_APER_I = 6'd14;
  localparam logic [5:0] W_APER_F = 6'd15;
  localparam logic [5:0] W_RSEC_H = 6'd16;
  localparam logic [5:0] W_RSEC_L = 6'd17;
  localparam logic [5:0] W_RNS_I  = 6'd18;
  localparam logic [5:0] W_RNS_F  = 6'd19;

  // command bit positions in the control word
  localparam int CMD_W  = 5;
  localparam int C_SNAP = 0;
  localparam int C_ADJ  = 1;
  localparam int C_PER  = 2;
  localparam int C_TIME = 3;
  localparam int C_CLR  = 4;
endpackage

// File: rtl/tod_cmd_regs.sv
module tod_cmd_regs
  import tod_pkg::*;
#(
  parameter int SEC_W     = 48,
  parameter int NS_INT_W  = 30,
  parameter int FRAC_W    = 8,
  parameter int ADJ_CNT_W = 32,
  parameter int unsigned MOD_INIT = 1_000_000_000,
  parameter int unsigned PER_INIT = 8,
  localparam int NS_W     = NS_INT_W + FRAC_W,
  localparam int SEC_HI_W = SEC_W - 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [5:0]           wr_word,
  input  logic [31:0]          wr_data,
  output logic [SEC_W-1:0]     ld_sec,
  output logic [NS_W-1:0]      ld_ns,
  output logic [NS_W-1:0]      per_stage,
  output logic [NS_W-1:0]      per_act,
  output logic [NS_W-1:0]      mod_val,
  output logic [ADJ_CNT_W-1:0] adj_n,
  output logic [NS_W-1:0]      adj_per,
  output logic [CMD_W-2:0]     ctrl_hi,
  output logic [CMD_W-1:0]     fire
);
  localparam logic [NS_W-1:0] PER_RST = {NS_INT_W'(PER_INIT), FRAC_W'(0)};
  localparam logic [NS_W-1:0] MOD_RST = {NS_INT_W'(MOD_INIT), FRAC_W'(0)};

  logic [CMD_W-1:0] ctrl_q;
  logic             wr_ctrl;

  assign wr_ctrl = wr_en && (wr_word == W_CTRL);
  // rising-edge detect against the previously written control value
  assign fire    = wr_ctrl ? (wr_data[CMD_W-1:0] & ~ctrl_q) : '0;
  assign ctrl_hi = ctrl_q[CMD_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ld_sec    <= '0;
      ld_ns     <= '0;
      per_stage <= PER_RST;
      mod_val   <= MOD_RST;
      adj_n     <= '0;
      adj_per   <= '0;
    end else if (wr_en) begin
      case (wr_word)
        W_CTRL:   ctrl_q <= wr_data[CMD_W-1:0];
        W_LSEC_H: ld_sec[SEC_W-1:32] <= wr_data[SEC_HI_W-1:0];
        W_LSEC_L: ld_sec[31:0] <= wr_data;
        W_LNS_I:  ld_ns[NS_W-1:FRAC_W] <= wr_data[NS_INT_W-1:0];
        W_LNS_F:  ld_ns[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
        W_PER_I:  per_stage[NS_W-1:FRAC_W] <= wr_data[NS_INT_W-1:0];
        W_PER_F:  per_stage[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
        W_MOD_I:  mod_val[NS_W-1:FRAC_W] <= wr_data[NS_INT_W-1:0];
        W_MOD_F:  mod_val[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
        W_ADJ_N:  adj_n <= wr_data[ADJ_CNT_W-1:0];
        W_APER_I: adj_per[NS_W-1:FRAC_W] <= wr_data[NS_INT_W-1:0];
        W_APER_F: adj_per[FRAC_W-1:0] <= wr_data[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  // active period only moves on the apply command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            per_act <= PER_RST;
    else if (fire[C_PER])  per_act <= per_stage;
  end

  assert_period_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire[C_PER] |=> $stable(per_act));

  assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && $past(wr_ctrl) && $past(wr_data[C_TIME])) |-> !fire[C_TIME]);
endmodule

// File: rtl/tod_adj_engine.sv
module tod_adj_engine #(
  parameter int NS_W      = 38,
  parameter int ADJ_CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 abort,
  input  logic [ADJ_CNT_W-1:0] adj_n,
  input  logic [NS_W-1:0]      adj_per,
  input  logic [NS_W-1:0]      norm_per,
  output logic [NS_W-1:0]      step
);
  logic [ADJ_CNT_W-1:0] remain;
  logic [NS_W-1:0]      aper_q;
  logic                 busy;

  assign busy = (remain != '0);
  assign step = busy ? aper_q : norm_per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      aper_q <= '0;
    end else if (abort) begin
      remain <= '0;
    end else if (start) begin
      remain <= adj_n;
      aper_q <= adj_per;
    end else if (busy) begin
      remain <= remain - 1'b1;
    end
  end

  assert_adj_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !abort) |=> (remain == $past(remain) - 1'b1));

  assert_no_spontaneous_adj_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !$rose(busy));
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SEC_W-1:0] ld_sec,
  input  logic [NS_W-1:0]  ld_ns,
  input  logic [NS_W-1:0]  step,
  input  logic [NS_W-1:0]  mod_val,
  output logic [SEC_W-1:0] sec_q,
  output logic [NS_W-1:0]  ns_q
);
  logic [NS_W:0]   sum;
  logic            wrap;
  logic [NS_W-1:0] ns_nxt;

  assign sum    = {1'b0, ns_q} + {1'b0, step};
  assign wrap   = (sum >= {1'b0, mod_val});
  assign ns_nxt = wrap ? NS_W'(sum - {1'b0, mod_val}) : sum[NS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (clr) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else if (load) begin
      sec_q <= ld_sec;
      ns_q  <= ld_ns;
    end else begin
      ns_q  <= ns_nxt;
      if (wrap) sec_q <= sec_q + 1'b1;
    end
  end

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sec_q == '0 && ns_q == '0));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (sec_q == $past(ld_sec) && ns_q == $past(ld_ns)));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int SEC_W     = 48,
  parameter int NS_INT_W  = 30,
  parameter int FRAC_W    = 8,
  parameter int ADJ_CNT_W = 32,
  parameter int unsigned MOD_INIT = 1_000_000_000,
  parameter int unsigned PER_INIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam int NS_W     = NS_INT_W + FRAC_W;
  localparam int SEC_HI_W = SEC_W - 32;

  logic [SEC_W-1:0]     ld_sec, sec_q, snap_sec;
  logic [NS_W-1:0]      ld_ns, ns_q, snap_ns;
  logic [NS_W-1:0]      per_stage, per_act, mod_val, adj_per, step;
  logic [ADJ_CNT_W-1:0] adj_n;
  logic [CMD_W-2:0]     ctrl_hi;
  logic [CMD_W-1:0]     fire;
  logic                 snap_done;
  logic                 wr_ctrl;

  assign wr_ctrl = wr_en && (addr == W_CTRL);

  tod_cmd_regs #(
    .SEC_W(SEC_W), .NS_INT_W(NS_INT_W), .FRAC_W(FRAC_W),
    .ADJ_CNT_W(ADJ_CNT_W), .MOD_INIT(MOD_INIT), .PER_INIT(PER_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(addr), .wr_data(wr_data),
    .ld_sec(ld_sec), .ld_ns(ld_ns), .per_stage(per_stage), .per_act(per_act),
    .mod_val(mod_val), .adj_n(adj_n), .adj_per(adj_per),
    .ctrl_hi(ctrl_hi), .fire(fire)
  );

  tod_adj_engine #(.NS_W(NS_W), .ADJ_CNT_W(ADJ_CNT_W)) u_adj (
    .clk(clk), .rst_n(rst_n), .start(fire[C_ADJ]), .abort(fire[C_CLR]),
    .adj_n(adj_n), .adj_per(adj_per), .norm_per(per_act), .step(step)
  );

  tod_accum #(.SEC_W(SEC_W), .NS_W(NS_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(fire[C_CLR]), .load(fire[C_TIME]),
    .ld_sec(ld_sec), .ld_ns(ld_ns), .step(step), .mod_val(mod_val),
    .sec_q(sec_q), .ns_q(ns_q)
  );

  // snapshot: all four read words captured on one edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_sec  <= '0;
      snap_ns   <= '0;
      snap_done <= 1'b0;
    end else if (fire[C_SNAP]) begin
      snap_sec  <= sec_q;
      snap_ns   <= ns_q;
      snap_done <= 1'b1;
    end else if (wr_ctrl && !wr_data[C_SNAP]) begin
      snap_done <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      W_CTRL:   rd_data = 32'({ctrl_hi, snap_done});
      W_LSEC_H: rd_data = 32'(ld_sec[SEC_W-1:32]);
      W_LSEC_L: rd_data = ld_sec[31:0];
      W_LNS_I:  rd_data = 32'(ld_ns[NS_W-1:FRAC_W]);
      W_LNS_F:  rd_data = 32'(ld_ns[FRAC_W-1:0]);
      W_PER_I:  rd_data = 32'(per_stage[NS_W-1:FRAC_W]);
      W_PER_F:  rd_data = 32'(per_stage[FRAC_W-1:0]);
      W_MOD_I:  rd_data = 32'(mod_val[NS_W-1:FRAC_W]);
      W_MOD_F:  rd_data = 32'(mod_val[FRAC_W-1:0]);
      W_ADJ_N:  rd_data = 32'(adj_n);
      W_APER_I: rd_data = 32'(adj_per[NS_W-1:FRAC_W]);
      W_APER_F: rd_data = 32'(adj_per[FRAC_W-1:0]);
      W_RSEC_H: rd_data = 32'(snap_sec[SEC_W-1:SEC_W-SEC_HI_W]);
      W_RSEC_L: rd_data = snap_sec[31:0];
      W_RNS_I:  rd_data = 32'(snap_ns[NS_W-1:FRAC_W]);
      W_RNS_F:  rd_data = 32'(snap_ns[FRAC_W-1:0]);
      default:  rd_data = '0;
    endcase
  end

  assert_snap_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire[C_SNAP] |=> (snap_done && snap_sec == $past(sec_q) && snap_ns == $past(ns_q)));

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire[C_SNAP] |=> ($stable(snap_sec) && $stable(snap_ns)));
endmodule

// File: tb/tod_clock_tb.sv
`timescale 1ns/1ps
module tod_clock_tb_top;
  localparam int unsigned MOD_T = 1000;

  // word indices and command values, taken from the requirements
  localparam logic [5:0] A_CTRL = 0, A_LSH = 4, A_LSL = 5, A_LNI = 6, A_LNF = 7;
  localparam logic [5:0] A_PI = 8, A_PF = 9, A_MI = 10, A_MF = 11, A_AN = 12;
  localparam logic [5:0] A_API = 14, A_APF = 15, A_RSH = 16, A_RSL = 17, A_RNI = 18, A_RNF = 19;
  localparam logic [31:0] K_SNAP = 1, K_ADJ = 2, K_PER = 4, K_TIME = 8, K_CLR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tod_clock #(.MOD_INIT(MOD_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [31:0] sec_h, sec_l, ns_i, ns_f, per_i, per_f, mod_i;
    logic [31:0] e_sec_h, e_sec_l, e_ns_i, e_ns_f;
  } vec_t;

  // three ticks between time load and snapshot
  localparam vec_t VECS [5] = '{
    '{32'd0, 32'd5,          32'd100, 32'h00, 32'd8, 32'h00, 32'd1000, 32'd0, 32'd5, 32'd124, 32'h00},
    '{32'd0, 32'd5,          32'd990, 32'h00, 32'd8, 32'h00, 32'd1000, 32'd0, 32'd6, 32'd14,  32'h00},
    '{32'd0, 32'd0,          32'd10,  32'h40, 32'd3, 32'h80, 32'd1000, 32'd0, 32'd0, 32'd20,  32'hC0},
    '{32'd0, 32'hFFFF_FFFF,  32'd995, 32'h00, 32'd8, 32'h00, 32'd1000, 32'd1, 32'd0, 32'd19,  32'h00},
    '{32'd0, 32'd0,          32'd495, 32'h00, 32'd7, 32'h00, 32'd500,  32'd0, 32'd1, 32'd16,  32'h00}
  };

  // one rising edge per write; called just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #0.1;
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] got;
    rd(a, got);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s word %0d: got 0x%08h expected 0x%08h", tag, a, got, exp);
    end
  endtask

  task automatic cmd(input logic [31:0] k);
    wr(A_CTRL, 0);
    wr(A_CTRL, k);
  endtask

  task automatic set_period(input logic [31:0] pi, input logic [31:0] pf);
    wr(A_PI, pi); wr(A_PF, pf);
    cmd(K_PER);
  endtask

  task automatic stage_time(input logic [31:0] sh, sl, ni, nf);
    wr(A_LSH, sh); wr(A_LSL, sl); wr(A_LNI, ni); wr(A_LNF, nf);
  endtask

  task automatic snap_chk(input string tag, input logic [31:0] sh, sl, ni, nf);
    chk(tag, A_RSH, sh); chk(tag, A_RSL, sl);
    chk(tag, A_RNI, ni); chk(tag, A_RNF, nf);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    chk("R1 period int", A_PI, 32'd8);
    chk("R1 period frac", A_PF, 32'd0);
    chk("R1 modulus int", A_MI, MOD_T);
    chk("R1 modulus frac", A_MF, 32'd0);
    chk("R1 control", A_CTRL, 32'd0);
    chk("R1 snap sec lo", A_RSL, 32'd0);
    chk("R1 snap ns", A_RNI, 32'd0);

    // R2 R3 R5: vector walk
    foreach (VECS[i]) begin
      wr(A_MI, VECS[i].mod_i);
      set_period(VECS[i].per_i, VECS[i].per_f);
      stage_time(VECS[i].sec_h, VECS[i].sec_l, VECS[i].ns_i, VECS[i].ns_f);
      cmd(K_TIME);
      wr(A_CTRL, 0);
      idle(2);
      wr(A_CTRL, K_SNAP);
      chk($sformatf("R8 done v%0d", i), A_CTRL, K_SNAP);
      snap_chk($sformatf("R2/R3/R5 v%0d", i), VECS[i].e_sec_h, VECS[i].e_sec_l,
               VECS[i].e_ns_i, VECS[i].e_ns_f);
    end

    wr(A_MI, MOD_T);
    set_period(8, 0);

    // R8: flag cleared by control write with bit0 low
    wr(A_CTRL, 0);
    chk("R8 flag cleared", A_CTRL, 32'd0);

    // R4: repeated bit3 without an intervening 0 does not reload
    stage_time(0, 0, 100, 0);
    cmd(K_TIME);            // time = 100
    wr(A_LNI, 300);         // 108
    wr(A_CTRL, K_TIME);     // no edge on bit3: 116
    wr(A_CTRL, K_TIME | K_SNAP); // captures 116
    snap_chk("R4 no re-arm", 0, 0, 116, 0);

    // R6: staged period without apply leaves rate unchanged
    wr(A_PI, 20);
    stage_time(0, 0, 0, 0);
    cmd(K_TIME);
    wr(A_CTRL, 0);
    idle(2);
    wr(A_CTRL, K_SNAP);
    snap_chk("R6 staged only", 0, 0, 24, 0);
    chk("R6 staged readback", A_PI, 32'd20);
    set_period(8, 0);

    // R7: 4 ticks at 1.125 then back to 8
    wr(A_AN, 4); wr(A_API, 1); wr(A_APF, 32'h20);
    stage_time(0, 0, 0, 0);
    cmd(K_TIME);            // 0
    wr(A_CTRL, 0);          // 8
    wr(A_CTRL, K_ADJ);      // 16, adjustment armed
    wr(A_CTRL, 0);          // 17.125
    idle(6);
    wr(A_CTRL, K_SNAP);
    snap_chk("R7 adjust window", 0, 0, 44, 32'h80);

    // R9: clear aborts adjustment, keeps period and modulus
    wr(A_AN, 100); wr(A_APF, 0);
    stage_time(0, 7, 0, 0);
    cmd(K_TIME);            // sec 7, ns 0
    wr(A_CTRL, 0);          // 8
    wr(A_CTRL, K_ADJ);      // 16
    wr(A_CTRL, 0);          // 17
    wr(A_CTRL, K_CLR);      // cleared
    wr(A_CTRL, 0);          // 8
    wr(A_CTRL, K_SNAP);
    snap_chk("R9 clear", 0, 0, 8, 0);
    chk("R9 period kept", A_PI, 32'd8);
    chk("R9 modulus kept", A_MI, MOD_T);

    // R10: field widths and unmapped words
    wr(A_MI, 32'hFFFF_FFFF);
    chk("R10 modulus width", A_MI, 32'h3FFF_FFFF);
    wr(A_MI, MOD_T);
    wr(A_LSH, 32'hFFFF_FFFF);
    chk("R10 seconds high width", A_LSH, 32'h0000_FFFF);
    wr(A_LNF, 32'hFFFF_FFFF);
    chk("R10 fraction width", A_LNF, 32'h0000_00FF);
    chk("R10 unmapped", 6'd13, 32'd0);
    chk("R10 unmapped high", 6'd40, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule